// File: doc/BRIEF.md
# Operand Fetch Stage with Split Immediate Constant

This block is the operand stage of a 16-bit load/store datapath with sixteen general registers. It holds the register file, selects the A operand with a bypass from the write-back bus, and builds the B operand either from a register or from immediate fields of the current instruction word. The stage ends in three registers: the A operand, the B operand and the store data that a later memory stage drives out.

Constants wider than four bits are made in two steps. A prefix instruction carries a 12-bit field that lands in the upper twelve bits of the B register. The instruction that follows supplies only the low nibble, so the pair yields a full 16-bit constant. The prefix and its successor form a pair that nothing may split. Two identical register copies give the two read ports, and every write goes to both copies.

Top module: `opf_stage`

## Requirements
- R1: After reset, a_q, b_q and sd_q are zero, no prefix is pending and every register reads as zero.
- R2: On a rising edge with run_en=1 and wr_en=1, wb_data is written to register wr_sel in both copies, so both read ports (src_a_sel, src_b_sel) return it from the next cycle on.
- R3: Register 0 reads as zero on both ports. A write to register 0 has no effect.
- R4: A read of a register that is written in the same cycle returns its old value on port B. It does so on port A too when no bypass applies.
- R5: With run_en=1, fwd_en=1, wr_en=1, wr_sel equal to src_a_sel and wr_sel nonzero, a_q loads wb_data. Otherwise a_q loads the port A read value.
- R6: The bypass is not taken when wr_sel is 0, when fwd_en is 0, when wr_en is 0, or when wr_sel differs from src_a_sel.
- R7: When no prefix is pending, b_mode selects b_q as follows: 2'b00 loads port B; 2'b01 loads insn[3:0] zero-extended; 2'b10 loads insn[3:0] sign-extended from bit 3.
- R8: b_mode=2'b11 (prefix, opcode 4'hD in insn[15:12]) loads b_q[15:4] from insn[11:0], keeps b_q[3:0] and marks a prefix pending.
- R9: When a prefix is pending, b_mode 2'b01 or 2'b10 loads only b_q[3:0] from insn[3:0] and keeps b_q[15:4], with no sign extension. b_mode 2'b00 loads the full port B value. Every enabled cycle other than a prefix clears the pending flag.
- R10: With run_en=1 and st_en=1, sd_q loads the port B read value. With st_en=0, sd_q holds.
- R11: With run_en=0, a_q, b_q, sd_q and the pending flag hold, and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Stage enable; low stalls the stage and blocks writes |
| insn | input | 16 | Current instruction word |
| src_a_sel | input | 4 | Register number for read port A |
| src_b_sel | input | 4 | Register number for read port B |
| wr_en | input | 1 | Write-back enable |
| wr_sel | input | 4 | Write-back register number |
| wb_data | input | 16 | Write-back result bus |
| fwd_en | input | 1 | Permits bypass of wb_data into A |
| b_mode | input | 2 | B operand source select |
| st_en | input | 1 | Latch store data from port B |
| a_q | output | 16 | A operand register |
| b_q | output | 16 | B operand register |
| sd_q | output | 16 | Store data register |

## Verification
The hardest state to reach is a pending prefix that survives one or more stalled cycles and then meets its low-nibble instruction. The bench issues a prefix, holds run_en low for a varying number of cycles with other inputs changing, and then completes the constant with both extension modes across many nibble and upper-field values. Same-cycle write and read is reached by sweeping every register as both the write target and the port A and port B source, with the bypass permitted and forbidden.

// File: rtl/opf_pkg.sv
package opf_pkg;
    typedef enum logic [1:0] {
        BSRC_REG  = 2'b00,
        BSRC_ZX4  = 2'b01,
        BSRC_SX4  = 2'b10,
        BSRC_HI12 = 2'b11
    } bsrc_e;

    localparam logic [3:0] PREFIX_OPCODE = 4'hD;
endpackage

// File: rtl/opf_regbank.sv
module opf_regbank #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (we && (waddr != '0)) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = (raddr == '0) ? '0 : mem_q[raddr];
    end
endmodule

// File: rtl/opf_afwd.sv
module opf_afwd #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          fwd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [AW-1:0] src_sel,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] wb_data,
    output logic [DW-1:0] a_next,
    output logic          hit
);
    always_comb begin
        hit    = fwd_en && wr_en && (wr_sel == src_sel) && (wr_sel != '0);
        a_next = hit ? wb_data : rd_data;
    end
endmodule

// File: rtl/opf_bsel.sv
module opf_bsel
    import opf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int IMMW = 4,
    localparam int HW  = DW - IMMW
) (
    input  bsrc_e         mode,
    input  logic          pend,
    input  logic [DW-1:0] insn,
    input  logic [DW-1:0] rd_b,
    input  logic [DW-1:0] b_cur,
    output logic [DW-1:0] b_next,
    output logic          pend_next
);
    logic [IMMW-1:0] nib;
    logic [HW-1:0]   hi_keep;

    always_comb begin
        nib       = insn[IMMW-1:0];
        hi_keep   = b_cur[DW-1:IMMW];
        b_next    = b_cur;
        pend_next = 1'b0;
        unique case (mode)
            BSRC_REG: b_next = rd_b;
            BSRC_ZX4: b_next = pend ? {hi_keep, nib} : {{HW{1'b0}}, nib};
            BSRC_SX4: b_next = pend ? {hi_keep, nib} : {{HW{nib[IMMW-1]}}, nib};
            BSRC_HI12: begin
                b_next    = {insn[HW-1:0], b_cur[IMMW-1:0]};
                pend_next = 1'b1;
            end
            default: b_next = b_cur;
        endcase
    end
endmodule

// File: rtl/opf_stage.sv
module opf_stage
    import opf_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16,
    parameter int IMMW = 4,
    localparam int AW  = $clog2(NREG),
    localparam int NCOPY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [DW-1:0] insn,
    input  logic [AW-1:0] src_a_sel,
    input  logic [AW-1:0] src_b_sel,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [DW-1:0] wb_data,
    input  logic          fwd_en,
    input  logic [1:0]    b_mode,
    input  logic          st_en,
    output logic [DW-1:0] a_q,
    output logic [DW-1:0] b_q,
    output logic [DW-1:0] sd_q
);
    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] sd;
        logic          pfx;
    } stage_t;

    stage_t st_d, st_q;

    logic [AW-1:0] rsel [NCOPY];
    logic [DW-1:0] rdat [NCOPY];
    logic          bank_we;

    assign bank_we = run_en && wr_en;
    assign rsel[0] = src_a_sel;
    assign rsel[1] = src_b_sel;

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        opf_regbank #(.DW(DW), .NREG(NREG)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .waddr (wr_sel),
            .wdata (wb_data),
            .raddr (rsel[c]),
            .rdata (rdat[c])
        );
    end

    logic [DW-1:0] a_nx;
    logic          a_hit;

    opf_afwd #(.DW(DW), .AW(AW)) u_afwd (
        .fwd_en  (fwd_en),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .src_sel (src_a_sel),
        .rd_data (rdat[0]),
        .wb_data (wb_data),
        .a_next  (a_nx),
        .hit     (a_hit)
    );

    logic [DW-1:0] b_nx;
    logic          pfx_nx;

    opf_bsel #(.DW(DW), .IMMW(IMMW)) u_bsel (
        .mode      (bsrc_e'(b_mode)),
        .pend      (st_q.pfx),
        .insn      (insn),
        .rd_b      (rdat[1]),
        .b_cur     (st_q.b),
        .b_next    (b_nx),
        .pend_next (pfx_nx)
    );

    always_comb begin
        st_d = st_q;
        if (run_en) begin
            st_d.a   = a_nx;
            st_d.b   = b_nx;
            st_d.pfx = pfx_nx;
            if (st_en) st_d.sd = rdat[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_q  = st_q.a;
    assign b_q  = st_q.b;
    assign sd_q = st_q.sd;

    // Stalled cycles freeze every output register and the pending prefix
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(a_q) && $stable(b_q) && $stable(sd_q) && $stable(st_q.pfx)));

    // Register 0 never yields anything but zero on port A
    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && src_a_sel == '0) |=> (a_q == '0));

    // Both copies agree whenever they are addressed alike
    assert_copies_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_sel == src_b_sel) |-> (rdat[0] == rdat[1]));

    // Bypass delivers the write-back value
    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && fwd_en && wr_en && wr_sel == src_a_sel && wr_sel != '0)
        |=> (a_q == $past(wb_data)));

    // Prefix fills upper field and keeps the low nibble
    assert_prefix_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && b_mode == 2'b11)
        |=> (b_q[DW-1:IMMW] == $past(insn[DW-IMMW-1:0]))
            && (b_q[IMMW-1:0] == $past(b_q[IMMW-1:0])) && st_q.pfx);

    // Completion after a prefix touches only the low nibble
    assert_prefix_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && st_q.pfx && (b_mode == 2'b01 || b_mode == 2'b10))
        |=> (b_q[DW-1:IMMW] == $past(b_q[DW-1:IMMW])) && !st_q.pfx);

    // Store data holds when not requested
    assert_store_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_en |=> $stable(sd_q));
endmodule

// File: tb/opf_stage_test.sv
module opf_stage_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [15:0] insn = '0;
    logic [3:0]  src_a_sel = '0;
    logic [3:0]  src_b_sel = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wb_data = '0;
    logic        fwd_en = 1'b0;
    logic [1:0]  b_mode = '0;
    logic        st_en = 1'b0;
    logic [15:0] a_q, b_q, sd_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] m_reg [16];
    logic [15:0] m_a, m_b, m_sd;
    logic        m_pfx;

    always #(CLK_PERIOD/2) clk = ~clk;

    opf_stage uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .insn(insn),
        .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .wr_en(wr_en),
        .wr_sel(wr_sel), .wb_data(wb_data), .fwd_en(fwd_en),
        .b_mode(b_mode), .st_en(st_en), .a_q(a_q), .b_q(b_q), .sd_q(sd_q)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: model next state from requirements, then compare after the edge
    task automatic cyc(input string tag);
        logic [15:0] ra, rb, na, nb, nsd;
        logic        np;
        ra = (src_a_sel == 0) ? 16'h0 : m_reg[src_a_sel];
        rb = (src_b_sel == 0) ? 16'h0 : m_reg[src_b_sel];
        na = m_a; nb = m_b; nsd = m_sd; np = m_pfx;
        if (run_en) begin
            na = (fwd_en && wr_en && wr_sel == src_a_sel && wr_sel != 0) ? wb_data : ra;
            np = 1'b0;
            case (b_mode)
                2'b00: nb = rb;
                2'b01: nb = m_pfx ? {m_b[15:4], insn[3:0]} : {12'h000, insn[3:0]};
                2'b10: nb = m_pfx ? {m_b[15:4], insn[3:0]} : {{12{insn[3]}}, insn[3:0]};
                default: begin nb = {insn[11:0], m_b[3:0]}; np = 1'b1; end
            endcase
            if (st_en) nsd = rb;
            if (wr_en && wr_sel != 0) m_reg[wr_sel] = wb_data;
        end
        @(posedge clk); #1;
        m_a = na; m_b = nb; m_sd = nsd; m_pfx = np;
        check(tag, "a_q", a_q, m_a);
        check(tag, "b_q", b_q, m_b);
        check(tag, "sd_q", sd_q, m_sd);
    endtask

    task automatic idle_inputs();
        run_en = 1'b1; wr_en = 1'b0; fwd_en = 1'b0; st_en = 1'b0;
        b_mode = 2'b00; insn = 16'h0; src_a_sel = 0; src_b_sel = 0;
    endtask

    function automatic logic [15:0] pat(input int i, input int k);
        return 16'((i * 16'h1357) ^ (k * 16'h9E37) ^ 16'hA5C3);
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_a = '0; m_b = '0; m_sd = '0; m_pfx = 1'b0;
        #(CLK_PERIOD*2 + 1);
        // R1: reset state
        check("R1", "a_q", a_q, 16'h0);
        check("R1", "b_q", b_q, 16'h0);
        check("R1", "sd_q", sd_q, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        idle_inputs();
        // R1: every register zero after reset
        for (int i = 0; i < 16; i++) begin
            src_a_sel = 4'(i); src_b_sel = 4'(i); st_en = 1'b1;
            cyc("R1");
        end
        // R2 R3: write each register (including attempt on r0)
        for (int i = 0; i < 16; i++) begin
            idle_inputs();
            wr_en = 1'b1; wr_sel = 4'(i); wb_data = pat(i, 1);
            src_a_sel = 4'((i + 5) % 16); src_b_sel = 4'((i + 9) % 16);
            cyc("R2");
        end
        // R2 R3 R10: read every pair on both ports
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                idle_inputs();
                src_a_sel = 4'(i); src_b_sel = 4'(j); st_en = ((i + j) % 3) != 0;
                cyc("R2_R3_R10");
            end
        end
        // R4 R5 R6: same-cycle write against each source, bypass on and off
        for (int w = 0; w < 16; w++) begin
            for (int f = 0; f < 2; f++) begin
                idle_inputs();
                wr_en = 1'b1; wr_sel = 4'(w); wb_data = pat(w, 2 + f);
                fwd_en = f[0]; src_a_sel = 4'(w); src_b_sel = 4'(w); st_en = 1'b1;
                cyc(f ? "R5" : "R4_R6");
                idle_inputs();
                wr_en = 1'b1; wr_sel = 4'(w); wb_data = pat(w, 7 + f);
                fwd_en = 1'b1; src_a_sel = 4'((w + 1) % 16);
                cyc("R6");
                idle_inputs();
                fwd_en = 1'b1; wr_sel = 4'(w); wb_data = 16'hFFFF; src_a_sel = 4'(w);
                cyc("R6");
            end
        end
        // R7: immediate nibble sweep, both extensions
        for (int n = 0; n < 16; n++) begin
            for (int md = 1; md < 3; md++) begin
                idle_inputs();
                b_mode = 2'(md); insn = {4'h2, 4'h3, 4'h1, 4'(n)};
                cyc("R7");
            end
        end
        // R8 R9 R11: prefix, stalls, completion
        for (int k = 0; k < 24; k++) begin
            idle_inputs();
            b_mode = 2'b11; insn = {4'hD, 12'(k * 12'h2B7 + 12'h801)};
            cyc("R8");
            for (int s = 0; s < (k % 3); s++) begin
                idle_inputs();
                run_en = 1'b0; b_mode = 2'(s); insn = 16'hFFFF; wr_en = 1'b1;
                wr_sel = 4'(k % 16); wb_data = 16'hDEAD; st_en = 1'b1;
                src_a_sel = 4'(k % 16); src_b_sel = 4'((k + 3) % 16);
                cyc("R11");
            end
            idle_inputs();
            b_mode = (k % 4 == 3) ? 2'b00 : ((k % 2 == 0) ? 2'b01 : 2'b10);
            insn = {4'h2, 4'h4, 4'h5, 4'(k % 16 | 8)};
            src_b_sel = 4'(k % 16);
            cyc("R9");
            idle_inputs();
            b_mode = 2'b10; insn = 16'h000F;
            cyc("R9");
        end
        // R3 R11: stalled write must leave register unchanged, r0 stays zero
        for (int i = 0; i < 16; i++) begin
            idle_inputs();
            run_en = 1'b0; wr_en = 1'b1; wr_sel = 4'(i); wb_data = 16'h0BAD;
            cyc("R11");
            idle_inputs();
            src_a_sel = 4'(i); src_b_sel = 4'(i); st_en = 1'b1;
            cyc("R11_R3");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule